// File: doc/BRIEF.md
# Byte-Lane Register Field Cell

This block stores one field of a memory-mapped control/status register. The field sits at a configurable bit span inside a bus word. Both a software write port and a hardware update port can load it. Software writes are merged one byte lane at a time. A field that crosses an 8-bit boundary is cut into slices, and each slice obeys the byte enable of its own lane. A parameter picks which writer wins when both write in the same cycle. Another parameter can make the field self-clearing, so that a written value lasts for only one cycle.

Every clock cycle, a small selector picks one update source for the field. The sources are SRC_HOLD (keep the value), SRC_SW (take the lane-merged software data), SRC_HW (take the hardware data) and SRC_CLEAR (load zero). Reset lies outside the selector and overrides it. Reset can be asynchronous or synchronous, and active-high or active-low. The selector's transitions are as follows:
- With only a software hit, it picks SRC_SW.
- With only a hardware hit, it picks SRC_HW.
- With both hits, it picks the configured winner.
- With neither hit, it picks SRC_CLEAR when self-clear is on and SRC_HOLD otherwise.

The cell gives optional AND, OR and XOR reductions of the stored value. It issues an elaboration-time warning for one configuration: hardware has priority, hardware loads on every cycle, and software is still given write access. In that configuration software could never change the field.

Top module: `regfield_cell`

## Requirements
- R1: While reset is active (its level is set by RST_ACT_LOW), the field equals RST_VAL. With RST_ASYNC=1 the value is loaded as soon as reset asserts, without waiting for a clock edge. With RST_ASYNC=0 it is loaded only at a rising clock edge.
- R2: Byte lane k covers bus bits 8k to 8k+7. When sw_wr is high and SW_WR=1, field bit i takes bus bit FLD_LSB+i whenever sw_be[(FLD_LSB+i)/8] is set. The field spans lanes FLD_LSB/8 to FLD_MSB/8, and the first and last of these lanes may be partial.
- R3: Field bits in lanes whose enable is clear keep their value during a software write. When sw_wr is low, sw_be has no effect. A software write counts only if at least one of the field's own lanes is enabled.
- R4: A hardware write loads hw_wdata. It requires HW_WR=1 and is gated by hw_wr_en according to HW_EN_MODE (0 = no enable, so the write happens on every cycle; 1 = active-high; 2 = active-low).
- R5: With HW_WINS=0, a cycle that has both writes applies only the software write. The hardware write is dropped entirely.
- R6: With HW_WINS=1, a cycle that has both writes applies only the hardware write. The software write is dropped.
- R7: With SELF_CLR=1, a cycle with no write loads zero. A written value is therefore visible for exactly one cycle.
- R8: With SELF_CLR=0, a cycle with no write keeps the field unchanged.
- R9: fld_and, fld_or and fld_xor are combinational AND, OR and XOR reductions of fld_q. Each one is driven to 0 when its enabling parameter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, with polarity set by RST_ACT_LOW |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | BUS_W | Software write data bus |
| sw_be | input | BUS_W/8 | Byte enables, qualified by sw_wr |
| hw_wr_en | input | 1 | Hardware write enable (used when HW_EN_MODE is not 0) |
| hw_wdata | input | FLD_MSB-FLD_LSB+1 | Hardware write data |
| fld_q | output | FLD_MSB-FLD_LSB+1 | Stored field value |
| fld_and | output | 1 | AND reduction of fld_q |
| fld_or | output | 1 | OR reduction of fld_q |
| fld_xor | output | 1 | XOR reduction of fld_q |

## Verification
A write, a self-clear or a hold that is presented before a rising edge shows on fld_q one edge later. The reductions follow fld_q in the same cycle. An asynchronous reset shows at once, while a synchronous reset waits for the next edge. The bench drives its inputs just after a falling edge and advances its model at the rising edge. It compares the design against the model one nanosecond after the next falling edge, and the reductions against the model value at that same point. For the asynchronous-reset test, the bench asserts reset in the middle of a cycle and samples before any edge. There the asynchronous instances must already show their reset values, while the synchronous instances must still show their old values.

// File: rtl/regfld_pkg.sv
package regfld_pkg;

    // Update source chosen for the field in one cycle
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_SW    = 2'd1,
        SRC_HW    = 2'd2,
        SRC_CLEAR = 2'd3
    } upd_src_e;

    localparam int HWEN_NONE = 0;
    localparam int HWEN_HIGH = 1;
    localparam int HWEN_LOW  = 2;

endpackage

// File: rtl/regfld_lane_merge.sv
module regfld_lane_merge #(
    parameter int BUS_W   = 32,
    parameter int FLD_LSB = 5,
    parameter int FLD_MSB = 19,
    localparam int W      = FLD_MSB - FLD_LSB + 1
) (
    input  logic [BUS_W-1:0]   wdata,
    input  logic [BUS_W/8-1:0] be,
    input  logic               strobe,
    input  logic [W-1:0]       cur,
    output logic [W-1:0]       merged,
    output logic               hit
);
    localparam int LO_LANE = FLD_LSB / 8;
    localparam int HI_LANE = FLD_MSB / 8;
    localparam int N_LANES = HI_LANE - LO_LANE + 1;

    logic [N_LANES-1:0] lane_on;

    // One slice per byte lane; the edge lanes may be partial
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        localparam int LANE = LO_LANE + k;
        localparam int BLO  = (LANE * 8 > FLD_LSB) ? LANE * 8 : FLD_LSB;
        localparam int BHI  = (LANE * 8 + 7 < FLD_MSB) ? LANE * 8 + 7 : FLD_MSB;
        assign lane_on[k] = strobe & be[LANE];
        assign merged[BHI-FLD_LSB:BLO-FLD_LSB] =
            lane_on[k] ? wdata[BHI:BLO] : cur[BHI-FLD_LSB:BLO-FLD_LSB];
    end

    assign hit = |lane_on;

endmodule

// File: rtl/regfld_arbiter.sv
module regfld_arbiter
    import regfld_pkg::*;
#(
    parameter bit HW_WINS  = 1'b0,
    parameter bit SELF_CLR = 1'b0
) (
    input  logic     sw_hit,
    input  logic     hw_hit,
    output upd_src_e src
);
    always_comb begin
        unique case ({sw_hit, hw_hit})
            2'b11:   src = HW_WINS ? SRC_HW : SRC_SW;
            2'b10:   src = SRC_SW;
            2'b01:   src = SRC_HW;
            default: src = SELF_CLR ? SRC_CLEAR : SRC_HOLD;
        endcase
    end
endmodule

// File: rtl/regfld_store.sv
module regfld_store
    import regfld_pkg::*;
#(
    parameter int           W           = 15,
    parameter bit           RST_ASYNC   = 1'b1,
    parameter bit           RST_ACT_LOW = 1'b1,
    parameter bit           HAS_RST     = 1'b1,
    parameter logic [W-1:0] RST_VAL     = '0
) (
    input  logic         clk,
    input  logic         rst_in,
    input  upd_src_e     src,
    input  logic [W-1:0] sw_val,
    input  logic [W-1:0] hw_val,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;
    logic         rst_act;

    assign rst_act = RST_ACT_LOW ? ~rst_in : rst_in;

    always_comb begin
        unique case (src)
            SRC_SW:    nxt = sw_val;
            SRC_HW:    nxt = hw_val;
            SRC_CLEAR: nxt = '0;
            default:   nxt = q;
        endcase
    end

    if (!HAS_RST) begin : g_norst
        always_ff @(posedge clk) q <= nxt;
    end else if (RST_ASYNC && RST_ACT_LOW) begin : g_async_lo
        always_ff @(posedge clk or negedge rst_in)
            if (!rst_in) q <= RST_VAL;
            else         q <= nxt;
    end else if (RST_ASYNC) begin : g_async_hi
        always_ff @(posedge clk or posedge rst_in)
            if (rst_in) q <= RST_VAL;
            else        q <= nxt;
    end else begin : g_sync
        always_ff @(posedge clk)
            if (rst_act) q <= RST_VAL;
            else         q <= nxt;
    end
endmodule

// File: rtl/regfld_reduce.sv
module regfld_reduce #(
    parameter int W       = 15,
    parameter bit HAS_AND = 1'b1,
    parameter bit HAS_OR  = 1'b1,
    parameter bit HAS_XOR = 1'b1
) (
    input  logic [W-1:0] q,
    output logic         y_and,
    output logic         y_or,
    output logic         y_xor
);
    if (HAS_AND) begin : g_and
        assign y_and = &q;
    end else begin : g_no_and
        assign y_and = 1'b0;
    end
    if (HAS_OR) begin : g_or
        assign y_or = |q;
    end else begin : g_no_or
        assign y_or = 1'b0;
    end
    if (HAS_XOR) begin : g_xor
        assign y_xor = ^q;
    end else begin : g_no_xor
        assign y_xor = 1'b0;
    end
endmodule

// File: rtl/regfield_cell.sv
module regfield_cell
    import regfld_pkg::*;
#(
    parameter int               BUS_W       = 32,
    parameter int               FLD_LSB     = 5,
    parameter int               FLD_MSB     = 19,
    parameter bit               RST_ASYNC   = 1'b1,
    parameter bit               RST_ACT_LOW = 1'b1,
    parameter bit               HAS_RST     = 1'b1,
    parameter logic [BUS_W-1:0] RST_VAL     = 32'h0000_4A5C,
    parameter bit               SW_WR       = 1'b1,
    parameter bit               HW_WR       = 1'b1,
    parameter int               HW_EN_MODE  = HWEN_HIGH,
    parameter bit               HW_WINS     = 1'b0,
    parameter bit               SELF_CLR    = 1'b0,
    parameter bit               HAS_AND     = 1'b1,
    parameter bit               HAS_OR      = 1'b1,
    parameter bit               HAS_XOR     = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_in,
    input  logic                       sw_wr,
    input  logic [BUS_W-1:0]           sw_wdata,
    input  logic [BUS_W/8-1:0]         sw_be,
    input  logic                       hw_wr_en,
    input  logic [FLD_MSB-FLD_LSB:0]   hw_wdata,
    output logic [FLD_MSB-FLD_LSB:0]   fld_q,
    output logic                       fld_and,
    output logic                       fld_or,
    output logic                       fld_xor
);
    localparam int W = FLD_MSB - FLD_LSB + 1;

    logic [W-1:0] sw_merged;
    logic         sw_hit;
    logic         hw_hit;
    logic         hw_gate;
    logic         rst_act;
    upd_src_e     src;
    logic         unused_inputs;

    assign unused_inputs = ^{sw_wdata, sw_be, hw_wr_en};
    assign rst_act       = RST_ACT_LOW ? ~rst_in : rst_in;

    always_comb begin
        unique case (HW_EN_MODE)
            HWEN_HIGH: hw_gate = hw_wr_en;
            HWEN_LOW:  hw_gate = ~hw_wr_en;
            default:   hw_gate = 1'b1;
        endcase
    end
    assign hw_hit = HW_WR & hw_gate;

    initial begin
        if (HW_WINS && HW_WR && (HW_EN_MODE == HWEN_NONE) && SW_WR)
            $warning("regfield_cell: hardware loads every cycle with priority; software writes can never land");
    end

    regfld_lane_merge #(.BUS_W(BUS_W), .FLD_LSB(FLD_LSB), .FLD_MSB(FLD_MSB)) u_merge (
        .wdata(sw_wdata), .be(sw_be), .strobe(sw_wr & SW_WR),
        .cur(fld_q), .merged(sw_merged), .hit(sw_hit)
    );

    regfld_arbiter #(.HW_WINS(HW_WINS), .SELF_CLR(SELF_CLR)) u_arb (
        .sw_hit(sw_hit), .hw_hit(hw_hit), .src(src)
    );

    regfld_store #(
        .W(W), .RST_ASYNC(RST_ASYNC), .RST_ACT_LOW(RST_ACT_LOW),
        .HAS_RST(HAS_RST), .RST_VAL(RST_VAL[W-1:0])
    ) u_store (
        .clk(clk), .rst_in(rst_in), .src(src),
        .sw_val(sw_merged), .hw_val(hw_wdata), .q(fld_q)
    );

    regfld_reduce #(.W(W), .HAS_AND(HAS_AND), .HAS_OR(HAS_OR), .HAS_XOR(HAS_XOR)) u_red (
        .q(fld_q), .y_and(fld_and), .y_or(fld_or), .y_xor(fld_xor)
    );

    // R1: the first sampled cycle after reset still shows the reset value
    assert_rst_value_R1: assert property (@(posedge clk) disable iff (rst_act)
        (HAS_RST && $fell(rst_act)) |-> fld_q == RST_VAL[W-1:0]);

    // R5: software wins a shared cycle when configured so
    assert_sw_wins_R5: assert property (@(posedge clk) disable iff (rst_act)
        (sw_hit && hw_hit && !HW_WINS) |=> fld_q == $past(sw_merged));

    // R6: hardware wins a shared cycle when configured so
    assert_hw_wins_R6: assert property (@(posedge clk) disable iff (rst_act)
        (hw_hit && (HW_WINS || !sw_hit)) |=> fld_q == $past(hw_wdata));

    // R7: an idle cycle clears a self-clearing field
    assert_self_clear_R7: assert property (@(posedge clk) disable iff (rst_act)
        (SELF_CLR && !sw_hit && !hw_hit) |=> fld_q == '0);

    // R8: an idle cycle keeps a plain field
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst_act)
        (!SELF_CLR && !sw_hit && !hw_hit) |=> $stable(fld_q));

endmodule

// File: tb/tb_regfield_cell.sv
module tb_regfield_cell;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_p;
    logic        sw_wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic        en_a = 1'b0, en_b = 1'b1, en_c = 1'b0;
    logic [31:0] hwbus = '0;
    logic [14:0] qa;
    logic [15:0] qb;
    logic [7:0]  qc;
    logic [11:0] qd;
    logic [3:0]  ra_and, ra_or, ra_xor;
    logic [31:0] ea, eb, ec, ed;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    assign rst_p = ~rst_n;
    always #(CLK_PERIOD/2) clk = ~clk;

    // A: lanes 0..2, async low, sw priority, active-high hw enable
    regfield_cell #(.FLD_LSB(5), .FLD_MSB(19), .RST_ASYNC(1), .RST_ACT_LOW(1),
        .RST_VAL(32'h4A5C), .HW_EN_MODE(1), .HW_WINS(0), .SELF_CLR(0)) dut (
        .clk(clk), .rst_in(rst_n), .sw_wr(sw_wr), .sw_wdata(wdata), .sw_be(be),
        .hw_wr_en(en_a), .hw_wdata(hwbus[14:0]), .fld_q(qa),
        .fld_and(ra_and[0]), .fld_or(ra_or[0]), .fld_xor(ra_xor[0]));
    // B: lanes 1..3, sync high, hw priority, active-low hw enable
    regfield_cell #(.FLD_LSB(12), .FLD_MSB(27), .RST_ASYNC(0), .RST_ACT_LOW(0),
        .RST_VAL(32'hBEEF), .HW_EN_MODE(2), .HW_WINS(1), .SELF_CLR(0)) dut_b (
        .clk(clk), .rst_in(rst_p), .sw_wr(sw_wr), .sw_wdata(wdata), .sw_be(be),
        .hw_wr_en(en_b), .hw_wdata(hwbus[15:0]), .fld_q(qb),
        .fld_and(ra_and[1]), .fld_or(ra_or[1]), .fld_xor(ra_xor[1]));
    // C: lanes 0..1, sync low, self-clearing
    regfield_cell #(.FLD_LSB(3), .FLD_MSB(10), .RST_ASYNC(0), .RST_ACT_LOW(1),
        .RST_VAL(32'h5A), .HW_EN_MODE(1), .HW_WINS(0), .SELF_CLR(1)) dut_c (
        .clk(clk), .rst_in(rst_n), .sw_wr(sw_wr), .sw_wdata(wdata), .sw_be(be),
        .hw_wr_en(en_c), .hw_wdata(hwbus[7:0]), .fld_q(qc),
        .fld_and(ra_and[2]), .fld_or(ra_or[2]), .fld_xor(ra_xor[2]));
    // D: lanes 2..3, async high, no hw enable (hw loads every cycle)
    regfield_cell #(.FLD_LSB(20), .FLD_MSB(31), .RST_ASYNC(1), .RST_ACT_LOW(0),
        .RST_VAL(32'h123), .HW_EN_MODE(0), .HW_WINS(0), .SELF_CLR(0)) dut_d (
        .clk(clk), .rst_in(rst_p), .sw_wr(sw_wr), .sw_wdata(wdata), .sw_be(be),
        .hw_wr_en(1'b0), .hw_wdata(hwbus[11:0]), .fld_q(qd),
        .fld_and(ra_and[3]), .fld_or(ra_or[3]), .fld_xor(ra_xor[3]));

    function automatic logic [31:0] fmask(input int lsb, input int msb);
        return (msb - lsb == 31) ? 32'hFFFF_FFFF : ((32'd1 << (msb - lsb + 1)) - 32'd1);
    endfunction

    // Next field value from the requirements
    function automatic logic [31:0] model(input int lsb, input int msb, input bit hwwins,
            input int enmode, input bit selfclr, input logic [31:0] cur, input logic en);
        logic [31:0] merged = cur;
        bit swhit = 1'b0, hwhit;
        for (int i = 0; i <= msb - lsb; i++) begin
            if (sw_wr && be[(lsb + i) / 8]) begin
                merged[i] = wdata[lsb + i];
                swhit = 1'b1;
            end
        end
        hwhit = (enmode == 0) ? 1'b1 : (enmode == 1) ? en : !en;
        if (swhit && (!hwhit || !hwwins)) return merged & fmask(lsb, msb);
        if (hwhit) return hwbus & fmask(lsb, msb);
        if (selfclr) return '0;
        return cur;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
            input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "A", {17'b0, qa}, ea);
        check(tag, "B", {16'b0, qb}, eb);
        check(tag, "C", {24'b0, qc}, ec);
        check(tag, "D", {20'b0, qd}, ed);
        check("R9", "A and", {31'b0, ra_and[0]}, {31'b0, ea[14:0] == 15'h7FFF});
        check("R9", "A or",  {31'b0, ra_or[0]},  {31'b0, |ea});
        check("R9", "B xor", {31'b0, ra_xor[1]}, {31'b0, ^eb});
        check("R9", "C or",  {31'b0, ra_or[2]},  {31'b0, |ec});
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            ea = 32'h4A5C; eb = 32'hBEEF; ec = 32'h5A; ed = 32'h123;
        end else begin
            ea = model(5, 19, 0, 1, 0, ea, en_a);
            eb = model(12, 27, 1, 2, 0, eb, en_b);
            ec = model(3, 10, 0, 1, 1, ec, en_c);
            ed = model(20, 31, 0, 0, 0, ed, 1'b0);
        end
        @(negedge clk); #1;
        check_all(tag);
    endtask

    task automatic idle_hw();
        en_a = 1'b0; en_b = 1'b1; en_c = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        ea = '0; eb = '0; ec = '0; ed = '0;
        // R1: reset state
        cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        // R2: full-lane software write, no enabled hardware writes
        sw_wr = 1'b1; be = 4'hF; wdata = 32'hC3A5_96E1; hwbus = 32'h1357_9BDF;
        cyc("R2");
        // R3: only lane 1 enabled, partial slices elsewhere keep value
        be = 4'b0010; wdata = 32'h0F0F_F00F;
        cyc("R3");
        // R3: strobe low, enables ignored
        sw_wr = 1'b0; be = 4'hF; wdata = 32'hFFFF_FFFF;
        cyc("R3");
        // R4: hardware enables active, no software
        en_a = 1'b1; en_b = 1'b0; en_c = 1'b1; hwbus = 32'h2468_ACE0;
        cyc("R4");
        // R7: idle cycle after write clears C
        idle_hw();
        cyc("R7");
        // R8: idle, A/B/C hold (D keeps loading hw)
        cyc("R8"); cyc("R8");
        // R5: shared cycle, software wins on A and D with partial lanes
        sw_wr = 1'b1; be = 4'b0101; wdata = 32'h5A5A_A5A5; hwbus = 32'h7777_1111;
        en_a = 1'b1; en_c = 1'b1;
        cyc("R5");
        // R6: shared cycle, hardware wins on B
        en_b = 1'b0; be = 4'hE; wdata = 32'h1111_2222; hwbus = 32'h0000_9876;
        cyc("R6");
        // R7: software write on C, then value lasts one cycle
        idle_hw(); be = 4'h3; wdata = 32'h0000_07F8;
        cyc("R7");
        sw_wr = 1'b0;
        cyc("R7");
        // R1: async reset mid-cycle, sync instances wait for the edge
        rst_n = 1'b0; #1;
        check("R1", "A async", {17'b0, qa}, 32'h4A5C);
        check("R1", "D async", {20'b0, qd}, 32'h123);
        check("R1", "B sync old", {16'b0, qb}, eb);
        check("R1", "C sync old", {24'b0, qc}, ec);
        cyc("R1");
        @(negedge clk); rst_n = 1'b1;
        cyc("R1 release");
        // Random mix for R5 / R6 interplay
        for (int n = 0; n < 400; n++) begin
            sw_wr = 1'($urandom); be = 4'($urandom); wdata = $urandom; hwbus = $urandom;
            en_a = 1'($urandom); en_b = 1'($urandom); en_c = 1'($urandom % 3 == 0);
            cyc("random R5/R6");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule